// File: doc/BRIEF.md
# PCI Interrupt Swizzle Router

This block gathers the level-sensitive interrupt pins of every device slot on a PCI bus and folds them onto the four shared interrupt lines that the bus carries. Each slot has four pins, A to D, numbered 0 to 3. The block rotates each pin number by the slot number, so pins are spread evenly across the four lines. All requests that land on the same line are combined as a wired-OR. The four resulting lines drive four fixed inputs of the system interrupt controller, 0x1B to 0x1E. The block holds every other controller input low.

The request vector is indexed by slot and then by pin. Bit `slot*4 + pin` carries pin `pin` of the device whose slot number is bits 15:11 of its device/function identifier. The controller vector is registered. A change on any request therefore reaches the controller one clock later, as a level that follows the request for as long as the request is held. Edge detection, acknowledge, masking, priority and message-signalled interrupts belong elsewhere.

Top module: `irq_swz_router`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every bit of `ctrl_irq` is 0 after that edge, whatever the requests are.
- R2: Request bit `irq_req[slot*4 + pin]` (slot 0 to 31 from device/function identifier bits 15:11, pin 0..3 = A..D) is routed to shared line `(slot + pin) mod 4`, the two low bits of the sum.
- R3: Shared line 0, 1, 2 and 3 drives `ctrl_irq` bit 0x1B, 0x1C, 0x1D and 0x1E respectively (bit 27 + line).
- R4: A shared line is high while at least one request routed to it is high, and goes low only once all requests routed to it are low.
- R5: Every `ctrl_irq` bit outside 0x1B to 0x1E is always 0.
- R6: A request change is visible on `ctrl_irq` exactly one clock edge later, not earlier, and the output holds its level, without pulsing, for as long as the requests stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 128 | Level interrupt requests, bit slot*4+pin |
| ctrl_irq | output | 32 | Interrupt controller inputs; only bits 27 to 30 are used |

## Verification
Each result of this block comes from a single register stage, so a request driven on a falling edge is due on `ctrl_irq` after the next rising edge. The bench drives requests on a falling edge and checks a moment later that the output still shows the old value. It then compares against the reference model on the following falling edge. Held-request runs are sampled on several falling edges in a row to show that the level does not pulse. A reset applied with all requests high is checked at the first falling edge after the reset edge.

// File: rtl/irq_swz_pkg.sv
// Package irq_swz_pkg
// Shared constants for the interrupt swizzle router: the pin count per slot
// and the number of shared bus lines, which the rotation arithmetic assumes
// is four (two-bit line index).
package irq_swz_pkg;
    localparam int PINS_PER_SLOT = 4;
    localparam int SHARED_LINES  = 4;
    localparam int LINE_IDX_W    = $clog2(SHARED_LINES);

    // Pin of a given slot that feeds a given shared line (inverse rotation).
    function automatic int pin_for_line(input int slot_id, input int line_id);
        return (line_id + SHARED_LINES - (slot_id % SHARED_LINES)) % SHARED_LINES;
    endfunction
endpackage

// File: rtl/irq_swz_slot_map.sv
// Module irq_swz_slot_map
// Rotates the four pins of one slot onto the four shared lines: pin p of
// slot s lands on line (s + p) mod 4. Pure wiring, no logic.
// Assumes SLOT_ID is the 5-bit slot number of the device in this slot.
module irq_swz_slot_map
    import irq_swz_pkg::*;
#(
    parameter int SLOT_ID = 0
) (
    input  logic [PINS_PER_SLOT-1:0] pins,
    output logic [SHARED_LINES-1:0]  lines
);
    genvar l;
    generate
        for (l = 0; l < SHARED_LINES; l++) begin : g_line
            localparam int PIN_SEL = pin_for_line(SLOT_ID, l);
            // Connect the one pin of this slot that rotates onto line l.
            assign lines[l] = pins[PIN_SEL];
        end
    endgenerate
endmodule

// File: rtl/irq_swz_merge.sv
// Module irq_swz_merge
// Wired-OR of the rotated lines of all slots: each shared line is high when
// any slot drives it. Assumes the input is grouped four lines per slot.
module irq_swz_merge
    import irq_swz_pkg::*;
#(
    parameter int NUM_SLOTS = 32
) (
    input  logic [NUM_SLOTS*SHARED_LINES-1:0] slot_lines,
    output logic [SHARED_LINES-1:0]           shared
);
    // OR each line position across every slot.
    always_comb begin
        shared = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            shared = shared | slot_lines[s*SHARED_LINES +: SHARED_LINES];
        end
    end
endmodule

// File: rtl/irq_swz_ctrl_drive.sv
// Module irq_swz_ctrl_drive
// Registers the four shared lines onto the controller input vector at bits
// BASE..BASE+3 and holds every other controller bit at zero.
// Assumes CTRL_W >= BASE + 4 and a synchronous active-low reset.
module irq_swz_ctrl_drive
    import irq_swz_pkg::*;
#(
    parameter int CTRL_W = 32,
    parameter int BASE   = 27
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [SHARED_LINES-1:0] shared,
    output logic [CTRL_W-1:0]       ctrl_q
);
    logic [CTRL_W-1:0] ctrl_d;

    genvar b;
    generate
        for (b = 0; b < CTRL_W; b++) begin : g_bit
            if (b >= BASE && b < BASE + SHARED_LINES) begin : g_used
                assign ctrl_d[b] = shared[b - BASE];
            end else begin : g_idle
                assign ctrl_d[b] = 1'b0;
            end
        end
    endgenerate

    // Output register: cleared by reset, otherwise follows the shared lines.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end
endmodule

// File: rtl/irq_swz_router.sv
// Module irq_swz_router (top)
// Routes per-slot level interrupt pins onto four shared lines by rotating the
// pin number with the slot number, ORs them, and drives controller inputs
// CTRL_BASE..CTRL_BASE+3 one clock later. Assumes request bit slot*4+pin and
// slot numbers 0..NUM_SLOTS-1 taken from device/function bits 15:11.
module irq_swz_router
    import irq_swz_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int CTRL_W    = 32,
    parameter int CTRL_BASE = 27
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_SLOTS*PINS_PER_SLOT-1:0] irq_req,
    output logic [CTRL_W-1:0]                 ctrl_irq
);
    localparam int ROUTED_W = NUM_SLOTS * SHARED_LINES;

    logic [ROUTED_W-1:0]     routed;
    logic [SHARED_LINES-1:0] shared;

    genvar s;
    generate
        for (s = 0; s < NUM_SLOTS; s++) begin : g_slot
            irq_swz_slot_map #(.SLOT_ID(s)) u_map (
                .pins  (irq_req[s*PINS_PER_SLOT +: PINS_PER_SLOT]),
                .lines (routed[s*SHARED_LINES +: SHARED_LINES])
            );
        end
    endgenerate

    irq_swz_merge #(.NUM_SLOTS(NUM_SLOTS)) u_merge (
        .slot_lines (routed),
        .shared     (shared)
    );

    irq_swz_ctrl_drive #(.CTRL_W(CTRL_W), .BASE(CTRL_BASE)) u_drive (
        .clk    (clk),
        .rst_n  (rst_n),
        .shared (shared),
        .ctrl_q (ctrl_irq)
    );
endmodule

// File: rtl/irq_swz_chk.sv
// Module irq_swz_chk
// Assertion checker bound to irq_swz_router. Computes the expected shared
// lines by forward rotation of every request bit and compares them with the
// registered controller outputs.
module irq_swz_chk #(
    parameter int NUM_SLOTS = 32,
    parameter int CTRL_W    = 32,
    parameter int CTRL_BASE = 27
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_SLOTS*4-1:0]   irq_req,
    input logic [CTRL_W-1:0]        ctrl_irq
);
    localparam logic [CTRL_W-1:0] WINDOW = {{(CTRL_W-4){1'b0}}, 4'hF} << CTRL_BASE;

    logic [3:0] exp_lines;
    logic       rst_seen_q;

    // Forward model: each request bit ORs into line (slot + pin) mod 4.
    always_comb begin
        exp_lines = '0;
        for (int i = 0; i < NUM_SLOTS*4; i++) begin
            exp_lines[((i / 4) + (i % 4)) % 4] = exp_lines[((i / 4) + (i % 4)) % 4] | irq_req[i];
        end
    end

    // R1: outputs sampled one edge after a reset edge must be all zero.
    always @(posedge clk) begin
        if (rst_seen_q) begin
            a_r1_reset_clear: assert (ctrl_irq == '0);
        end
        rst_seen_q <= !rst_n;
    end

    // R2, R3, R4: controller window equals the rotated OR of the previous requests.
    a_r2_rotated_or: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ctrl_irq[CTRL_BASE +: 4] == $past(exp_lines)));

    // R5: bits outside the window stay low.
    a_r5_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((ctrl_irq & ~WINDOW) == '0));

    // R6: unchanged requests leave the output level unchanged on the next edge.
    a_r6_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(irq_req)) |=> $stable(ctrl_irq));
endmodule

bind irq_swz_router irq_swz_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .CTRL_W    (CTRL_W),
    .CTRL_BASE (CTRL_BASE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_req  (irq_req),
    .ctrl_irq (ctrl_irq)
);

// File: tb/test_irq_swz_router.sv
module test_irq_swz_router;
    localparam int NS = 32;
    localparam int CW = 32;
    localparam int BASE = 27;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NS*4-1:0] irq_req = '0;
    logic [CW-1:0]   ctrl_irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    irq_swz_router #(.NUM_SLOTS(NS), .CTRL_W(CW), .CTRL_BASE(BASE)) i_irq_swz_router (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .ctrl_irq(ctrl_irq)
    );

    always #5 clk = ~clk;

    // Reference: from the requirements, line = (slot + pin) & 3, output bit 27 + line.
    function automatic logic [CW-1:0] model(input logic [NS*4-1:0] r);
        logic [CW-1:0] o = '0;
        for (int slot = 0; slot < NS; slot++) begin
            for (int pin = 0; pin < 4; pin++) begin
                if (r[slot*4 + pin]) o[BASE + ((slot + pin) & 3)] = 1'b1;
            end
        end
        return o;
    endfunction

    task automatic check(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Drive on a falling edge, confirm no early change, check one edge later.
    task automatic apply(input string req, input logic [NS*4-1:0] v);
        logic [CW-1:0] prev;
        @(negedge clk);
        prev = model(irq_req);
        irq_req = v;
        #1 check({req, " R6 no early change"}, ctrl_irq, prev);
        @(negedge clk);
        check(req, ctrl_irq, model(v));
    endtask

    initial begin
        logic [NS*4-1:0] v;
        void'($urandom(32'h5EED_1234));
        // R1: reset state
        irq_req = '1;
        @(negedge clk); @(negedge clk);
        check("R1 reset with all requests high", ctrl_irq, '0);
        rst_n = 1'b1;
        irq_req = '0;
        @(negedge clk);
        check("R1 idle after reset", ctrl_irq, '0);

        // R2/R3: every slot and pin alone
        for (int slot = 0; slot < NS; slot++) begin
            for (int pin = 0; pin < 4; pin++) begin
                v = '0;
                v[slot*4 + pin] = 1'b1;
                apply("R2 R3 single pin", v);
            end
        end

        // R4: two requests on line 0 (slot 0 pin A, slot 3 pin B); release one at a time
        v = '0; v[0] = 1'b1; v[3*4 + 1] = 1'b1;
        apply("R4 two sharers", v);
        v[0] = 1'b0;
        apply("R4 one sharer left", v);
        check("R4 line0 still high", ctrl_irq, 32'h1 << BASE);
        v[3*4 + 1] = 1'b0;
        apply("R4 all released", v);
        check("R4 line0 low", ctrl_irq, '0);

        // R6: held level does not pulse
        v = '0; v[5*4 + 2] = 1'b1;
        apply("R6 hold start", v);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R6 level held", ctrl_irq, model(v));
        end

        // R4/R5: random patterns, dense and sparse
        for (int k = 0; k < 300; k++) begin
            v = {$urandom, $urandom, $urandom, $urandom};
            if (k % 2 == 1) v = v & {$urandom, $urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom, $urandom};
            if (k % 7 == 0) v = '0;
            apply("R4 R5 random", v);
            check("R5 unused bits low", ctrl_irq & ~(32'hF << BASE), '0);
        end

        // R1: reset in mid-run with requests present
        @(negedge clk);
        irq_req = '1;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset", ctrl_irq, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 after reset release", ctrl_irq, model(irq_req));

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule